// File: doc/BRIEF.md
# CAN Bit Timing Unit

This block derives a time quantum from the system clock through a programmable prescaler. It splits every nominal bit on a CAN-style NRZ bus into four consecutive segments: synchronization, propagation, phase buffer 1 and phase buffer 2. The line carries no clock, so the unit re-aligns its bit grid to recessive-to-dominant (falling) edges on the already-synchronized receive line. When the unit is idle, a falling edge starts a bit directly (hard synchronization). While bits are running, an edge stretches or trims a phase segment (resynchronization), and the correction is limited by a programmable jump width.

The segment lengths, the prescaler value and the jump width are plain configuration inputs. The unit produces a one-cycle strobe at the sample point together with the sampled line value, a one-cycle bit-start strobe for a transmitter, and the index of the current segment. It also reports whether the configured bit length is legal. While the configuration is illegal, the unit does nothing.

Top module: `can_bit_timer`

## Requirements
- R1: One time quantum lasts 2*(brp+1) clock cycles, where brp is a 6-bit unsigned input (0..63). Every segment is a whole number of quanta.
- R2: Within a bit, the segment output steps in the order 0 (sync, 1 quantum), 1 (propagation, prop_seg+1 quanta), 2 (phase 1, ph1_seg+1 quanta), 3 (phase 2, ph2_seg+1 quanta). Each length field is 3 bits wide.
- R3: With no falling edge on rx, the interval from one tx_stb to the next is N*2*(brp+1) cycles, where N = 4+prop_seg+ph1_seg+ph2_seg. This holds unchanged over at least five consecutive bits.
- R4: cfg_valid is 1 exactly when 8 <= N <= 25. While it is 0, the unit returns to idle and issues no strobes. After the configuration becomes legal again, the unit stays idle until a falling edge arrives.
- R5: sample_stb pulses once per bit, (1+prop_seg+1+ph1_seg+1) quanta after tx_stb, when no edge has occurred in that bit. sample_bit then carries the value of rx at that clock edge.
- R6: In idle with a legal configuration, a falling edge on rx gives tx_stb and segment 0 in the following cycle. This starts the bit, and its quantum counter begins at zero.
- R7: A falling edge in quantum q of a bit, where q is counted from 0 at bit start and lies in the propagation or phase 1 segment, lengthens phase 1 by min(q, sjw+1) quanta. sjw is a 2-bit input.
- R8: A falling edge during phase 2 with r quanta of the bit left (r = N - q) restarts the bit at once (tx_stb in the next cycle) if r <= sjw+1. Otherwise it shortens phase 2 by sjw+1 quanta.
- R9: A falling edge in the sync segment causes no correction. After one correction, further edges in the same bit are ignored.
- R10: tx_stb and sample_stb are each high for exactly one clock cycle.
- R11: After reset, all counters are clear, the strobes are low, the segment is 0 and the unit is idle until the first falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| brp | input | 6 | Prescaler value; quantum = 2*(brp+1) clocks |
| prop_seg | input | 3 | Propagation segment length minus one |
| ph1_seg | input | 3 | Phase buffer 1 length minus one |
| ph2_seg | input | 3 | Phase buffer 2 length minus one |
| sjw | input | 2 | Jump width minus one |
| rx | input | 1 | Synchronized receive line, 1 = recessive |
| cfg_valid | output | 1 | Bit length lies within 8..25 quanta |
| sample_stb | output | 1 | One-cycle pulse at the sample point |
| sample_bit | output | 1 | Line value taken at the sample point |
| tx_stb | output | 1 | One-cycle pulse at each bit start |
| seg | output | 2 | Current segment: 0 sync, 1 prop, 2 phase 1, 3 phase 2 |

## Verification
The bench places falling edges at chosen quantum positions in each region of the bit. It targets edges in the sync quantum, late edges whose phase error is above and below the jump width, and early edges in phase 2 on either side of the restart threshold. A design that confused the two phase directions, or ignored the sjw clamp, would put the next bit start several quanta away from the predicted cycle. The bench also sends a second edge in an already-corrected bit, where a design that corrected twice would stretch the bit again. It checks the 7/8 and 25-quanta length limits and the 128-clock quantum, where an off-by-one in the prescaler or the range check shows up as a wrong period or a unit that never starts.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_PROP = 2'd1,
        SEG_PH1  = 2'd2,
        SEG_PH2  = 2'd3
    } seg_e;
endpackage

// File: rtl/cbt_cfg.sv
module cbt_cfg #(
    parameter int SEG_W  = 3,
    parameter int SJW_W  = 2,
    parameter int MIN_TQ = 8,
    parameter int MAX_TQ = 25
) (
    input  logic [SEG_W-1:0] prop_seg,
    input  logic [SEG_W-1:0] ph1_seg,
    input  logic [SEG_W-1:0] ph2_seg,
    input  logic [SJW_W-1:0] sjw,
    output logic [SEG_W:0]   prop_len,
    output logic [SEG_W:0]   ph1_len,
    output logic [SEG_W:0]   ph2_len,
    output logic [SJW_W:0]   sjw_len,
    output logic             cfg_ok
);
    localparam int LEN_W = SEG_W + 1;
    localparam int TOT_W = SEG_W + 3;

    logic [TOT_W-1:0] total;

    always_comb begin
        prop_len = LEN_W'(prop_seg) + LEN_W'(1);
        ph1_len  = LEN_W'(ph1_seg) + LEN_W'(1);
        ph2_len  = LEN_W'(ph2_seg) + LEN_W'(1);
        sjw_len  = (SJW_W+1)'(sjw) + (SJW_W+1)'(1);
        total    = TOT_W'(1) + TOT_W'(prop_len) + TOT_W'(ph1_len) + TOT_W'(ph2_len);
        cfg_ok   = (total >= TOT_W'(MIN_TQ)) && (total <= TOT_W'(MAX_TQ));
    end
endmodule

// File: rtl/cbt_quanta.sv
module cbt_quanta #(
    parameter int BRP_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [BRP_W-1:0] brp,
    output logic             tq_end
);
    localparam int PC_W = BRP_W + 1;

    logic [PC_W-1:0] pcnt_d, pcnt_q;

    always_comb begin
        tq_end = run && (pcnt_q >= {brp, 1'b1});
        pcnt_d = pcnt_q + PC_W'(1);
        if (!run || restart || tq_end) begin
            pcnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else begin
            pcnt_q <= pcnt_d;
        end
    end

    // R1
    quantum_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$past(restart) && !$past(tq_end))
            |-> (pcnt_q == PC_W'($past(pcnt_q) + PC_W'(1))));
endmodule

// File: rtl/cbt_seq.sv
module cbt_seq
    import cbt_pkg::*;
#(
    parameter int SEG_W = 3,
    parameter int SJW_W = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_ok,
    input  logic           tq_end,
    input  logic           rx,
    input  logic [SEG_W:0] prop_len,
    input  logic [SEG_W:0] ph1_len,
    input  logic [SEG_W:0] ph2_len,
    input  logic [SJW_W:0] sjw_len,
    output logic           running,
    output logic           restart,
    output seg_e           seg,
    output logic           smp_stb,
    output logic           smp_bit,
    output logic           tx_stb
);
    localparam int LEN_W = SEG_W + 1;
    localparam int QC_W  = LEN_W + 1;
    localparam int EXT_W = SJW_W + 1;
    localparam int E_W   = LEN_W + 2;

    typedef struct packed {
        logic             running;
        seg_e             seg;
        logic [QC_W-1:0]  qcnt;
        logic [EXT_W-1:0] ext;
        logic [EXT_W-1:0] shrt;
        logic             rs_done;
        logic             rx_prev;
        logic             smp_stb;
        logic             smp_bit;
        logic             tx_stb;
    } st_t;

    st_t d, q;
    logic             fall, hop;
    logic [E_W-1:0]   e;
    logic [QC_W-1:0]  rem;
    logic [EXT_W-1:0] ext_n, shrt_n;

    function automatic st_t to_sync(st_t s);
        st_t r   = s;
        r.running = 1'b1;
        r.seg     = SEG_SYNC;
        r.qcnt    = '0;
        r.ext     = '0;
        r.shrt    = '0;
        r.rs_done = 1'b0;
        r.tx_stb  = 1'b1;
        return r;
    endfunction

    always_comb begin
        d         = q;
        d.smp_stb = 1'b0;
        d.tx_stb  = 1'b0;
        d.rx_prev = rx;
        fall      = q.rx_prev & ~rx;
        restart   = 1'b0;
        hop       = 1'b0;
        e         = '0;
        rem       = '0;
        ext_n     = q.ext;
        shrt_n    = q.shrt;
        if (!cfg_ok) begin
            d.running = 1'b0;
            d.seg     = SEG_SYNC;
            d.qcnt    = '0;
            d.ext     = '0;
            d.shrt    = '0;
            d.rs_done = 1'b0;
        end else if (!q.running) begin
            if (fall) begin
                d       = to_sync(d);
                restart = 1'b1;
            end
        end else begin
            if (fall && !q.rs_done && q.seg != SEG_SYNC) begin
                d.rs_done = 1'b1;
                if (q.seg == SEG_PH2) begin
                    rem = QC_W'(ph2_len) - q.qcnt;
                    if (rem <= QC_W'(sjw_len)) begin
                        hop = 1'b1;
                    end else begin
                        shrt_n = EXT_W'(sjw_len);
                    end
                end else begin
                    e = (q.seg == SEG_PROP) ? E_W'(q.qcnt) + E_W'(1)
                                            : E_W'(prop_len) + E_W'(q.qcnt) + E_W'(1);
                    ext_n = (e > E_W'(sjw_len)) ? EXT_W'(sjw_len) : EXT_W'(e);
                end
            end
            d.ext  = ext_n;
            d.shrt = shrt_n;
            if (hop) begin
                d       = to_sync(d);
                restart = 1'b1;
            end else if (tq_end) begin
                case (q.seg)
                    SEG_SYNC: begin
                        d.seg  = SEG_PROP;
                        d.qcnt = '0;
                    end
                    SEG_PROP: begin
                        if (q.qcnt == QC_W'(prop_len) - QC_W'(1)) begin
                            d.seg  = SEG_PH1;
                            d.qcnt = '0;
                        end else begin
                            d.qcnt = q.qcnt + QC_W'(1);
                        end
                    end
                    SEG_PH1: begin
                        if (q.qcnt == QC_W'(ph1_len) + QC_W'(ext_n) - QC_W'(1)) begin
                            d.seg     = SEG_PH2;
                            d.qcnt    = '0;
                            d.smp_stb = 1'b1;
                            d.smp_bit = rx;
                        end else begin
                            d.qcnt = q.qcnt + QC_W'(1);
                        end
                    end
                    default: begin
                        if (q.qcnt == QC_W'(ph2_len) - QC_W'(shrt_n) - QC_W'(1)) begin
                            d = to_sync(d);
                        end else begin
                            d.qcnt = q.qcnt + QC_W'(1);
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.rx_prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign running = q.running;
    assign seg     = q.seg;
    assign smp_stb = q.smp_stb;
    assign smp_bit = q.smp_bit;
    assign tx_stb  = q.tx_stb;

    // R2
    seg_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.running && $past(q.running) && q.seg != $past(q.seg))
            |-> (2'(q.seg) == 2'(2'($past(q.seg)) + 2'd1)));
    // R4
    idle_bad_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ok |=> (!q.running && !q.tx_stb && !q.smp_stb));
    // R5
    sample_at_ph1_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.smp_stb |-> ($past(q.seg) == SEG_PH1 && q.seg == SEG_PH2));
    // R6
    hard_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ok && !q.running && fall) |=> (q.running && q.tx_stb && q.seg == SEG_SYNC));
    // R9
    one_resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.rs_done && $past(q.rs_done) && q.seg != SEG_SYNC)
            |-> ($stable(q.ext) && $stable(q.shrt)));
    // R10
    tx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.tx_stb |=> !q.tx_stb);
    // R10
    smp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.smp_stb |=> !q.smp_stb);
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
    import cbt_pkg::*;
#(
    parameter int BRP_W  = 6,
    parameter int SEG_W  = 3,
    parameter int SJW_W  = 2,
    parameter int MIN_TQ = 8,
    parameter int MAX_TQ = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BRP_W-1:0] brp,
    input  logic [SEG_W-1:0] prop_seg,
    input  logic [SEG_W-1:0] ph1_seg,
    input  logic [SEG_W-1:0] ph2_seg,
    input  logic [SJW_W-1:0] sjw,
    input  logic             rx,
    output logic             cfg_valid,
    output logic             sample_stb,
    output logic             sample_bit,
    output logic             tx_stb,
    output logic [1:0]       seg
);
    logic [SEG_W:0] prop_len, ph1_len, ph2_len;
    logic [SJW_W:0] sjw_len;
    logic           cfg_ok, running, restart, tq_end;
    seg_e           seg_cur;

    cbt_cfg #(.SEG_W(SEG_W), .SJW_W(SJW_W), .MIN_TQ(MIN_TQ), .MAX_TQ(MAX_TQ)) u_cfg (
        .prop_seg(prop_seg), .ph1_seg(ph1_seg), .ph2_seg(ph2_seg), .sjw(sjw),
        .prop_len(prop_len), .ph1_len(ph1_len), .ph2_len(ph2_len),
        .sjw_len(sjw_len), .cfg_ok(cfg_ok)
    );

    cbt_quanta #(.BRP_W(BRP_W)) u_quanta (
        .clk(clk), .rst_n(rst_n), .run(running), .restart(restart),
        .brp(brp), .tq_end(tq_end)
    );

    cbt_seq #(.SEG_W(SEG_W), .SJW_W(SJW_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .cfg_ok(cfg_ok), .tq_end(tq_end), .rx(rx),
        .prop_len(prop_len), .ph1_len(ph1_len), .ph2_len(ph2_len), .sjw_len(sjw_len),
        .running(running), .restart(restart), .seg(seg_cur),
        .smp_stb(sample_stb), .smp_bit(sample_bit), .tx_stb(tx_stb)
    );

    assign cfg_valid = cfg_ok;
    assign seg       = 2'(seg_cur);
endmodule

// File: tb/can_bit_timer_tb.sv
module can_bit_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] brp = '0;
    logic [2:0] prop_seg = '0, ph1_seg = '0, ph2_seg = '0;
    logic [1:0] sjw = '0;
    logic       rx = 1'b1;
    logic       cfg_valid, sample_stb, sample_bit, tx_stb;
    logic [1:0] seg;

    int tests = 0, fails = 0;
    int L, N, S, P, SJ;

    always #2 clk = ~clk;

    can_bit_timer u_dut (
        .clk(clk), .rst_n(rst_n), .brp(brp), .prop_seg(prop_seg), .ph1_seg(ph1_seg),
        .ph2_seg(ph2_seg), .sjw(sjw), .rx(rx), .cfg_valid(cfg_valid),
        .sample_stb(sample_stb), .sample_bit(sample_bit), .tx_stb(tx_stb), .seg(seg)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_seg(input int qi);
        if (qi == 0) return 0;
        if (qi < 1 + P) return 1;
        if (qi < S) return 2;
        return 3;
    endfunction

    function automatic int exp_next(input int te);
        int qi = te / L;
        int rem;
        if (qi == 0) return N * L;
        if (qi < S) return N * L + ((qi < SJ) ? qi : SJ) * L;
        rem = N - qi;
        if (rem <= SJ) return te + 1;
        return (N - SJ) * L;
    endfunction

    function automatic int bit_len(input int p, input int a, input int c);
        return 4 + p + a + c;
    endfunction

    task automatic setup(input int b, input int p, input int a, input int c, input int s);
        brp = 6'(b); prop_seg = 3'(p); ph1_seg = 3'(a); ph2_seg = 3'(c); sjw = 2'(s);
        L = 2 * (b + 1); P = p + 1; N = bit_len(p, a, c); S = 2 + p + 1 + a; SJ = s + 1;
    endtask

    // idle the unit via an illegal setting, then hard-sync with a new one
    task automatic sync_unit(input int b, input int p, input int a, input int c, input int s);
        @(negedge clk);
        prop_seg = '0; ph1_seg = '0; ph2_seg = '0; rx = 1'b1;
        repeat (3) @(negedge clk);
        setup(b, p, a, c, s);
        @(negedge clk);
        rx = 1'b0;
        @(negedge clk);
        chk(tx_stb && seg == 2'd0, "R6 hard sync start", int'(tx_stb), 1);
    endtask

    task automatic run_bit(input int r1, input int d1, input int r2, input int d2,
                           output int per, output int smp_t, output int smp_v,
                           output int smp_n, output int seg_bad);
        int t = 0;
        per = -1; smp_t = -1; smp_v = -1; smp_n = 0; seg_bad = 0;
        while (per < 0 && t < 10000) begin
            if (t == r1) rx = 1'b1;
            if (t == d1) rx = 1'b0;
            if (t == r2) rx = 1'b1;
            if (t == d2) rx = 1'b0;
            @(negedge clk);
            t++;
            if (sample_stb) begin
                smp_n++; smp_t = t; smp_v = int'(sample_bit);
            end
            if (tx_stb) per = t;
            else if (d1 < 0 && int'(seg) != exp_seg(t / L)) seg_bad++;
        end
    endtask

    task automatic bit_plain(input int r1, input int exp_v);
        int per, st, sv, sn, sb;
        run_bit(r1, -1, -1, -1, per, st, sv, sn, sb);
        chk(per == N * L, "R3 R1 bit period", per, N * L);
        chk(st == S * L, "R5 sample time", st, S * L);
        chk(sv == exp_v, "R5 sample value", sv, exp_v);
        chk(sn == 1, "R10 one sample pulse", sn, 1);
        chk(sb == 0, "R2 segment order", sb, 0);
    endtask

    task automatic bit_edge(input int te);
        int per, st, sv, sn, sb, ex;
        string tag;
        ex = exp_next(te);
        if (te / L == 0) tag = "R9 sync edge";
        else if (te / L < S) tag = "R7 late edge";
        else tag = "R8 early edge";
        run_bit(1, te, -1, -1, per, st, sv, sn, sb);
        chk(per == ex, tag, per, ex);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int per, st, sv, sn, sb, cnt;
        void'($urandom(32'd4711));
        setup(1, 2, 3, 2, 1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(!tx_stb && !sample_stb && seg == 2'd0, "R11 reset outputs", int'(tx_stb), 0);
        cnt = 0;
        repeat (40) begin @(negedge clk); cnt += int'(tx_stb) + int'(sample_stb); end
        chk(cnt == 0, "R11 idle until edge", cnt, 0);

        // R4 length limits
        setup(0, 1, 1, 1, 0);
        @(negedge clk);
        chk(cfg_valid == 1'b0, "R4 7 quanta illegal", int'(cfg_valid), 0);
        cnt = 0;
        repeat (10) begin
            rx = 1'b0; @(negedge clk); cnt += int'(tx_stb) + int'(sample_stb);
            rx = 1'b1; @(negedge clk); cnt += int'(tx_stb) + int'(sample_stb);
        end
        chk(cnt == 0, "R4 no strobes when illegal", cnt, 0);
        setup(0, 2, 1, 1, 0);
        @(negedge clk);
        chk(cfg_valid == 1'b1, "R4 8 quanta legal", int'(cfg_valid), 1);
        cnt = 0;
        repeat (30) begin @(negedge clk); cnt += int'(tx_stb) + int'(sample_stb); end
        chk(cnt == 0, "R4 stays idle without edge", cnt, 0);
        setup(0, 7, 7, 7, 0);
        @(negedge clk);
        chk(cfg_valid == 1'b1, "R4 25 quanta legal", int'(cfg_valid), 1);

        // directed: L=4, N=11, S=8, SJ=2
        sync_unit(1, 2, 3, 2, 1);
        repeat (5) bit_plain(-1, 0);
        bit_plain(1, 1);
        bit_edge(5);      // R7 q=1 -> +1
        bit_edge(26);     // R7 q=6 -> clamp +2
        bit_edge(2);      // R9 sync quantum
        bit_edge(33);     // R8 shorten
        bit_edge(41);     // R8 restart r=1
        bit_edge(37);     // R8 restart r=2 = limit
        // R9 second edge in the same bit ignored
        run_bit(1, 4, 5, 24, per, st, sv, sn, sb);
        chk(per == N * L + L, "R9 second edge ignored", per, N * L + L);

        // R1 largest quantum, longest bit
        sync_unit(63, 7, 7, 7, 3);
        bit_plain(-1, 0);
        bit_edge(1285);   // R7 q=10 -> clamp +4

        // random configurations and edge placements
        for (int i = 0; i < 30; i++) begin
            int b, p, a, c, s;
            b = int'($urandom % 4);
            s = int'($urandom % 4);
            do begin
                p = int'($urandom % 8); a = int'($urandom % 8); c = int'($urandom % 8);
            end while (bit_len(p, a, c) < 8);
            sync_unit(b, p, a, c, s);
            bit_plain(-1, 0);
            bit_edge(2 + int'($urandom % (N * L - 2)));
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule